// File: doc/BRIEF.md
# Utility-Driven Way Partitioner for a Shared Last-Level Cache

This block decides how many ways of a shared last-level cache each core may hold. Every cache access is reported to it with the requesting core, whether the access hit, and the recency position (0 = most recently used) at which a shadow tag directory for that core found the line. For each core the block keeps one saturating hit counter per recency position. These counters form a per-core hit-versus-ways curve: the sum of the first N counters is the number of hits the core would have had with N ways.

After a fixed number of accesses (the epoch, counted over all cores), the block recomputes the split. Every core first receives one way. The remaining ways are then handed out one per clock cycle, each to the core whose next way would add the most hits. When the last way has been placed, the new per-core targets appear on the output together with a one-cycle done pulse, and every hit counter is halved. This lets recent behaviour weigh more without discarding older history. A victim selector reads the targets. With dynamic mode off, the output is a fixed even split and no repartition takes place.

Top module: `upart_alloc`

## Requirements
- R1: After reset, `alloc_done` is low and every core's target equals NUM_WAYS/NUM_CORES, with one extra way for each core whose index is below NUM_WAYS mod NUM_CORES (with 4 cores and 8 ways, every core gets 2).
- R2: An access with `acc_valid` and `acc_hit` high, taken while no repartition is in progress, adds one to the counter of core `acc_core` at recency position `acc_pos`. An access with `acc_hit` low changes no counter.
- R3: A hit counter that holds its maximum value (all ones, CNT_W bits) keeps that value when it is hit again. It does not wrap.
- R4: Valid accesses are counted over all cores. With `dyn_en` high, the access that makes the count reach EPOCH starts exactly one repartition and restarts the count. No repartition starts at any other access.
- R5: A repartition starts with one way for each core. It then assigns the other NUM_WAYS-NUM_CORES ways one at a time. Each way goes to the core whose hit counter at recency position equal to its current way count is the largest.
- R6: When several cores tie for the largest marginal gain, the way goes to the one with the lowest index.
- R7: The targets on `alloc_ways` always add up to NUM_WAYS, and every core has at least one way. Core i's count is bits [i*AW +: AW], where AW = clog2(NUM_WAYS+1).
- R8: `alloc_done` is a one-cycle pulse. It is high in the cycle that follows the (NUM_WAYS-NUM_CORES+1)-th rising edge after the edge that samples the epoch's final access. The new targets appear in that same cycle. With `dyn_en` high, the targets stay unchanged in every other cycle.
- R9: On completing a repartition, every hit counter of every core is replaced by its value shifted right by one.
- R10: While `dyn_en` is low, `alloc_ways` shows the even split of R1, no repartition or done pulse occurs, and counters keep accumulating without halving. When `dyn_en` goes high, `alloc_ways` shows the targets of the last completed repartition.
- R11: Hit accesses that arrive while a repartition is in progress are not recorded in any hit counter. They still count toward the epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dyn_en | input | 1 | High: periodic repartitioning; low: fixed even split |
| acc_valid | input | 1 | One last-level cache access this cycle |
| acc_core | input | CORE_W | Requesting core index |
| acc_hit | input | 1 | Access hit in the requesting core's shadow directory |
| acc_pos | input | WAY_W | Recency position of the hit, 0 = most recent |
| alloc_ways | output | NUM_CORES*AW | Per-core target way counts, core 0 in the low bits |
| alloc_done | output | 1 | One-cycle pulse: new targets valid |

## Verification
The assertions check four properties on every cycle: the targets always sum to the associativity and never drop to zero for a core, the done pulse never lasts two cycles, targets change only on a done pulse while dynamic mode holds, and a saturated counter stays saturated until a halving. The choices themselves can only be shown by the directed scenarios, because the counters are visible only through the allocation they produce. These choices are the greedy winner order, lowest-index tie-breaking, halving between epochs, freezing during the search, counters that keep accumulating in static mode, and the exact epoch and done timing. Each scenario is built so that a wrong rule gives a different final split.

// File: rtl/upart_pkg.sv
package upart_pkg;

    typedef enum logic {
        PH_IDLE,
        PH_PICK
    } upart_phase_e;

    // even share of ways for core idx; low-numbered cores absorb the remainder
    function automatic int even_share(input int idx, input int cores, input int ways);
        return ways / cores + ((idx < (ways % cores)) ? 1 : 0);
    endfunction

endpackage

// File: rtl/upart_hit_mon.sv
module upart_hit_mon #(
    parameter int NUM_WAYS = 16,
    parameter int CNT_W    = 16,
    parameter int WAY_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              inc,
    input  logic [WAY_W-1:0]                  pos,
    input  logic                              halve,
    output logic [NUM_WAYS-1:0][CNT_W-1:0]    cnt
);

    logic [NUM_WAYS-1:0][CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (halve) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                cnt_d[w] = cnt_q[w] >> 1;
            end
        end else if (inc) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if ((pos == WAY_W'(w)) && (cnt_q[w] != {CNT_W{1'b1}})) begin
                    cnt_d[w] = cnt_q[w] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/upart_greedy_pick.sv
module upart_greedy_pick #(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 16,
    parameter int CNT_W     = 16,
    parameter int AW        = 5,
    parameter int CORE_W    = 2
) (
    input  logic [NUM_CORES-1:0][NUM_WAYS-1:0][CNT_W-1:0] cnt,
    input  logic [NUM_CORES-1:0][AW-1:0]                  share,
    output logic [CORE_W-1:0]                             winner
);

    logic [NUM_CORES-1:0][CNT_W-1:0] gain;

    // marginal gain: counter at the position one past the current share
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            gain[c] = '0;
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (share[c] == AW'(w)) begin
                    gain[c] = cnt[c][w];
                end
            end
        end
    end

    // strict compare keeps the lowest index on ties
    always_comb begin
        logic [CNT_W-1:0] best;
        best   = gain[0];
        winner = '0;
        for (int c = 1; c < NUM_CORES; c++) begin
            if (gain[c] > best) begin
                best   = gain[c];
                winner = CORE_W'(c);
            end
        end
    end

endmodule

// File: rtl/upart_alloc.sv
module upart_alloc
    import upart_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 16,
    parameter int CNT_W     = 16,
    parameter int EPOCH     = 1000,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int AW       = $clog2(NUM_WAYS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dyn_en,
    input  logic                      acc_valid,
    input  logic [CORE_W-1:0]         acc_core,
    input  logic                      acc_hit,
    input  logic [WAY_W-1:0]          acc_pos,
    output logic [NUM_CORES*AW-1:0]   alloc_ways,
    output logic                      alloc_done
);

    localparam int EPOCH_W = (EPOCH > 1) ? $clog2(EPOCH) : 1;
    localparam int SPARE   = NUM_WAYS - NUM_CORES;

    typedef logic [AW-1:0] share_t;

    typedef struct packed {
        upart_phase_e                 phase;
        logic [EPOCH_W-1:0]           epoch;
        share_t                       spare;
        share_t [NUM_CORES-1:0]       work;
        share_t [NUM_CORES-1:0]       tgt;
        logic                         done;
    } ctl_t;

    ctl_t                                        ctl_d, ctl_q, ctl_rst;
    share_t [NUM_CORES-1:0]                      even_split;
    logic [NUM_CORES-1:0][NUM_WAYS-1:0][CNT_W-1:0] hit_cnt;
    logic [CORE_W-1:0]                           win;
    logic                                        record;
    logic                                        halve;
    logic                                        last_acc;

    assign record   = acc_valid && acc_hit && (ctl_q.phase == PH_IDLE);
    assign last_acc = (ctl_q.epoch == EPOCH_W'(EPOCH - 1));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign even_split[c] = AW'(even_share(c, NUM_CORES, NUM_WAYS));

        upart_hit_mon #(
            .NUM_WAYS (NUM_WAYS),
            .CNT_W    (CNT_W),
            .WAY_W    (WAY_W)
        ) u_mon (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (record && (acc_core == CORE_W'(c))),
            .pos   (acc_pos),
            .halve (halve),
            .cnt   (hit_cnt[c])
        );

        assign alloc_ways[c*AW +: AW] = dyn_en ? ctl_q.tgt[c] : even_split[c];
    end

    upart_greedy_pick #(
        .NUM_CORES (NUM_CORES),
        .NUM_WAYS  (NUM_WAYS),
        .CNT_W     (CNT_W),
        .AW        (AW),
        .CORE_W    (CORE_W)
    ) u_pick (
        .cnt    (hit_cnt),
        .share  (ctl_q.work),
        .winner (win)
    );

    always_comb begin
        ctl_rst       = '0;
        ctl_rst.phase = PH_IDLE;
        ctl_rst.work  = even_split;
        ctl_rst.tgt   = even_split;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        halve      = 1'b0;

        if (acc_valid) begin
            ctl_d.epoch = last_acc ? '0 : ctl_q.epoch + 1'b1;
        end

        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (acc_valid && last_acc && dyn_en) begin
                    ctl_d.phase = PH_PICK;
                    ctl_d.spare = AW'(SPARE);
                    for (int c = 0; c < NUM_CORES; c++) begin
                        ctl_d.work[c] = AW'(1);
                    end
                end
            end
            PH_PICK: begin
                if (ctl_q.spare == '0) begin
                    ctl_d.tgt   = ctl_q.work;
                    ctl_d.done  = 1'b1;
                    ctl_d.phase = PH_IDLE;
                    halve       = 1'b1;
                end else begin
                    ctl_d.work[win] = ctl_q.work[win] + 1'b1;
                    ctl_d.spare     = ctl_q.spare - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= ctl_rst;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign alloc_done = ctl_q.done;

endmodule

// File: rtl/upart_alloc_chk.sv
module upart_alloc_chk #(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 16,
    parameter int CNT_W     = 16,
    parameter int AW        = 5
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic                                        dyn_en,
    input logic                                        alloc_done,
    input logic [NUM_CORES*AW-1:0]                     alloc_ways,
    input logic [NUM_CORES-1:0][NUM_WAYS-1:0][CNT_W-1:0] hit_cnt
);

    int way_sum;

    always_comb begin
        way_sum = 0;
        for (int c = 0; c < NUM_CORES; c++) begin
            way_sum = way_sum + int'(alloc_ways[c*AW +: AW]);
        end
    end

    AST_WAYS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        way_sum == NUM_WAYS); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |=> !alloc_done); // R8

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_en && $past(dyn_en) && !alloc_done) |-> $stable(alloc_ways)); // R8

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        AST_MIN_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_ways[c*AW +: AW] != '0); // R7

        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_cnt[c][w] == {CNT_W{1'b1}}) |=>
                (alloc_done || (hit_cnt[c][w] == {CNT_W{1'b1}}))); // R3
        end
    end

endmodule

bind upart_alloc upart_alloc_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_WAYS  (NUM_WAYS),
    .CNT_W     (CNT_W),
    .AW        (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dyn_en     (dyn_en),
    .alloc_done (alloc_done),
    .alloc_ways (alloc_ways),
    .hit_cnt    (hit_cnt)
);

// File: tb/upart_alloc_bench.sv
`timescale 1ns/1ps
module upart_alloc_bench;

    localparam int NC   = 4;
    localparam int NW   = 8;
    localparam int CW   = 8;
    localparam int EP   = 1000;
    localparam int AW   = $clog2(NW + 1);
    localparam int REM  = NW - NC;
    localparam int CMAX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dyn_en = 1'b1;
    logic              acc_valid = 1'b0;
    logic [1:0]        acc_core = '0;
    logic              acc_hit = 1'b0;
    logic [2:0]        acc_pos = '0;
    logic [NC*AW-1:0]  alloc_ways;
    logic              alloc_done;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int m_cnt [NC][NW];
    int m_epoch = 0;
    int e_sh [NC];

    always #2.5 clk = ~clk;

    upart_alloc #(.NUM_CORES(NC), .NUM_WAYS(NW), .CNT_W(CW), .EPOCH(EP)) u_upart_alloc (
        .clk(clk), .rst_n(rst_n), .dyn_en(dyn_en), .acc_valid(acc_valid),
        .acc_core(acc_core), .acc_hit(acc_hit), .acc_pos(acc_pos),
        .alloc_ways(alloc_ways), .alloc_done(alloc_done)
    );

    always @(negedge clk) if (rst_n && alloc_done) pulses++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int field(input int c);
        return int'(alloc_ways[c*AW +: AW]);
    endfunction

    task automatic check_alloc(input string req, input int e0, input int e1,
                               input int e2, input int e3);
        int exp [NC];
        int act_p, exp_p, sum;
        exp = '{e0, e1, e2, e3};
        act_p = 0; exp_p = 0; sum = 0;
        for (int c = 0; c < NC; c++) begin
            act_p = act_p * 16 + field(c);
            exp_p = exp_p * 16 + exp[c];
            sum   = sum + field(c);
        end
        check(act_p == exp_p, req, "targets (hex c0..c3)", act_p, exp_p);
        check(sum == NW, "R7", "target sum", sum, NW);
    endtask

    // bench model of the greedy split from its own counter copy (R5, R6)
    task automatic model_split();
        for (int c = 0; c < NC; c++) e_sh[c] = 1;
        for (int r = 0; r < REM; r++) begin
            int best, win;
            best = -1; win = 0;
            for (int c = 0; c < NC; c++) begin
                if (m_cnt[c][e_sh[c]] > best) begin
                    best = m_cnt[c][e_sh[c]];
                    win  = c;
                end
            end
            e_sh[win]++;
        end
    endtask

    task automatic send(input int core, input bit hit, input int pos);
        @(negedge clk);
        acc_valid = 1'b1; acc_core = 2'(core); acc_hit = hit; acc_pos = 3'(pos);
        @(posedge clk);
        #1 acc_valid = 1'b0;
        if (hit && m_cnt[core][pos] < CMAX) m_cnt[core][pos]++;
        m_epoch = (m_epoch == EP - 1) ? 0 : m_epoch + 1;
    endtask

    task automatic hits(input int core, input int pos, input int n);
        repeat (n) send(core, 1'b1, pos);
    endtask

    // pad with misses, issue the closing access, follow the repartition
    task automatic close_epoch(input int bcore, input int bn);
        int p0, early;
        while (m_epoch < EP - 1) send(0, 1'b0, 0);
        p0 = pulses;
        send(0, 1'b0, 0);
        if (dyn_en) begin
            model_split();
            early = 0;
            for (int k = 1; k <= REM + 1; k++) begin
                @(negedge clk);
                if (k <= bn) begin
                    acc_valid = 1'b1; acc_core = 2'(bcore); acc_hit = 1'b1; acc_pos = 3'd1;
                    m_epoch++;
                end
                @(posedge clk);
                #1 acc_valid = 1'b0;
                if (k <= REM && alloc_done) early++;
            end
            check(early == 0, "R8", "done before search end", early, 0);
            check(alloc_done == 1'b1, "R8", "done at search end", alloc_done, 1);
            check_alloc("R5", e_sh[0], e_sh[1], e_sh[2], e_sh[3]);
            @(posedge clk); #1;
            check(alloc_done == 1'b0, "R8", "done one cycle", alloc_done, 0);
            check(pulses == p0 + 1, "R4", "pulses per epoch", pulses - p0, 1);
            for (int c = 0; c < NC; c++)
                for (int w = 0; w < NW; w++) m_cnt[c][w] = m_cnt[c][w] >> 1;
        end else begin
            repeat (REM + 2) @(posedge clk);
            #1;
            check(pulses == p0, "R10", "no pulse in static mode", pulses - p0, 0);
            check_alloc("R10", 2, 2, 2, 2);
        end
    endtask

    task automatic t_reset();
        check(alloc_done == 1'b0, "R1", "done after reset", alloc_done, 0);
        check_alloc("R1", 2, 2, 2, 2);
    endtask

    task automatic t_tie_and_freeze();
        close_epoch(3, 4);               // hits to core 3 land during the search (R11)
        check_alloc("R6", 5, 1, 1, 1);   // all gains zero: lowest core wins each way
        close_epoch(0, 0);
        check_alloc("R11", 5, 1, 1, 1);  // frozen hits must not favour core 3
    endtask

    task automatic t_greedy();
        hits(2, 1, 50); hits(2, 2, 40);
        repeat (30) begin send(1, 1'b1, 1); send(3, 1'b0, 1); end   // R2 misses ignored
        hits(0, 1, 20); hits(0, 2, 5);
        close_epoch(0, 0);
        check_alloc("R2", 2, 2, 3, 1);
    endtask

    task automatic t_halve();
        hits(1, 1, 10); hits(1, 2, 24); hits(1, 3, 24);
        close_epoch(0, 0);
        check_alloc("R9", 1, 4, 2, 1);
    endtask

    task automatic t_saturate();
        hits(0, 1, 300);
        for (int p = 1; p <= 4; p++) hits(1, p, 100);
        close_epoch(0, 0);
        check_alloc("R3", 2, 4, 1, 1);
    endtask

    task automatic t_static();
        @(negedge clk) dyn_en = 1'b0;
        #1 check_alloc("R10", 2, 2, 2, 2);
        for (int p = 1; p <= 3; p++) hits(3, p, 60);
        close_epoch(0, 0);
        @(negedge clk) dyn_en = 1'b1;
        #1 check_alloc("R10", 2, 4, 1, 1);
        close_epoch(0, 0);
        check_alloc("R10", 2, 1, 1, 4);  // static-epoch hits kept unhalved
    endtask

    initial begin
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) m_cnt[c][w] = 0;
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1'b1;
        #1 t_reset();
        t_tie_and_freeze();
        t_greedy();
        t_halve();
        t_saturate();
        t_static();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule